// File: doc/BRIEF.md
# MDIO Management Slave

This block is the PHY-side end of a two-wire serial management bus. It is clocked only by the management clock `mdc`, which the station supplies and may stop whenever the bus is idle. On every rising `mdc` edge it samples the data line. It recognises a frame by its start pattern and decodes the two opcode bits, a 5-bit device address and a 5-bit register address. It then either collects 16 write bits into a local bank of 32 sixteen-bit registers, or returns 16 read bits on the shared line.

The shared line is open-drain in style. The slave never drives a one. It has a data output and an output-enable, and the enable is low whenever the slave is not actively driving, so an external pull-up holds the line high. The block's own device address comes from five strap inputs captured while reset is asserted. Once reset is released, the strap inputs have no effect.

After reset the block holds off for a short quiet period. After that quiet period, and after any aborted frame, it waits for a run of idle-high bits before it accepts a new start pattern. A frame that ends normally returns the block straight to idle.

Top module: `mdio_slave`

## Requirements
- R1: `mdio_i` is sampled on rising `mdc` edges. A frame is the start bits 0,1, two opcode bits, a 5-bit device address, a 5-bit register address, two turnaround bits and 16 data bits. Every field is sent most significant bit first.
- R2: An opcode of 0 then 1 is a write. When the device address matches, the 16 data bits are stored in the addressed register, and the slave keeps `mdio_oe` low for the whole frame. The master's turnaround bits are not checked.
- R3: An opcode of 1 then 0 is a read. When the device address matches, `mdio_oe` stays low during the first turnaround bit. The slave then drives 0 during the second turnaround bit, then the 16 register bits, and releases the line after the last bit.
- R4: A frame whose device address differs from the latched address is followed to its end. It causes no drive and no register change.
- R5: Opcodes 00 and 11 abort the frame with no drive and no register change. The slave then needs `IDLE_RUN` consecutive ones (default 8) before it accepts a new start.
- R6: The device address is taken from `strap_addr` while `rst` is high. Changes on `strap_addr` after reset do not affect which frames are answered.
- R7: The first `QUIET_CYCLES` (default 1) rising `mdc` edges after reset release are ignored. A frame whose start bit falls on such an edge does not write any register.
- R8: `mdio_oe` is low during reset and whenever the slave is not driving. `mdio_oe` and `mdio_o` change only on falling `mdc` edges, so they are steady across every rising edge.
- R9: After a complete frame the slave accepts a new frame following a single idle bit, with no preamble.
- R10: `mdc` may stop for any length of time while the bus is idle. The next frame after it restarts is handled normally.
- R11: All 32 registers reset to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock from the station; the block's only clock |
| rst | input | 1 | Synchronous active-high reset, sampled on `mdc` |
| mdio_i | input | 1 | Sampled level of the shared data line |
| strap_addr | input | 5 | Device address straps, captured during reset |
| mdio_o | output | 1 | Value to drive on the line when enabled |
| mdio_oe | output | 1 | Output-enable for the line driver; low means released |

## Verification
A wrong frame state shows at the ports within the same frame: the enable rises in the wrong slot, the turnaround zero is missing, or the read bits are shifted by one. All of these appear by the second turnaround bit of a read. A bad register update or a false match stays hidden until a later read of that register, so every directed write is followed by a readback. The random mix interleaves reads and writes to matching and non-matching addresses. Drive edge timing is checked by sampling the outputs just before and just after each rising edge.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PHY_AW  = 5;
    localparam int REG_AW  = 5;
    localparam int DATA_W  = 16;
    localparam int NUM_REGS = 1 << REG_AW;
    localparam int DCNT_W  = $clog2(DATA_W);
    localparam int FCNT_W  = (PHY_AW > REG_AW) ? $clog2(PHY_AW) : $clog2(REG_AW);

    localparam logic [1:0] OP_RD = 2'b10;
    localparam logic [1:0] OP_WR = 2'b01;

    typedef enum logic [3:0] {
        ST_HUNT  = 4'd0,
        ST_IDLE  = 4'd1,
        ST_START = 4'd2,
        ST_OP1   = 4'd3,
        ST_OP2   = 4'd4,
        ST_PHY   = 4'd5,
        ST_REG   = 4'd6,
        ST_TA1   = 4'd7,
        ST_TA2   = 4'd8,
        ST_DATA  = 4'd9
    } rx_state_e;

    typedef struct packed {
        logic [1:0]        op;
        logic [PHY_AW-1:0] phy;
        logic [REG_AW-1:0] regad;
    } frame_hdr_t;

    typedef struct packed {
        logic              en;
        logic [REG_AW-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic logic op_is_legal(input logic [1:0] op);
        return (op == OP_RD) || (op == OP_WR);
    endfunction

    function automatic logic op_is_read(input logic [1:0] op);
        return op == OP_RD;
    endfunction

endpackage

// File: rtl/mdio_regbank.sv
module mdio_regbank
    import mdio_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  wr_req_t             wr,
    input  logic [REG_AW-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data
);

    logic [DATA_W-1:0] regs_q [NUM_REGS];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rst) begin
                regs_q[i] <= '0;
            end else if (wr.en && (wr.addr == REG_AW'(i))) begin
                regs_q[i] <= wr.data;
            end
        end
    end

    assign rd_data = regs_q[rd_addr];

endmodule

// File: rtl/mdio_frame_rx.sv
module mdio_frame_rx
    import mdio_pkg::*;
#(
    parameter int IDLE_RUN     = 8,
    parameter int QUIET_CYCLES = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                mdio_i,
    input  logic [PHY_AW-1:0]   my_addr,
    input  logic [DATA_W-1:0]   rd_data,
    output logic [REG_AW-1:0]   rd_addr,
    output wr_req_t             wr,
    output logic                rd_active,
    output logic                ta2_phase,
    output logic                tx_bit
);

    localparam int RUN_W = $clog2(IDLE_RUN + 1);
    localparam int QW    = (QUIET_CYCLES > 0) ? $clog2(QUIET_CYCLES + 1) : 1;
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(IDLE_RUN - 1);

    rx_state_e         state_q;
    frame_hdr_t        hdr_q;
    logic [FCNT_W-1:0] fcnt_q;
    logic [DCNT_W-1:0] dcnt_q;
    logic [DATA_W-1:0] shreg_q;
    logic              hit_q;
    logic [RUN_W-1:0]  run_q;
    logic [QW-1:0]     quiet_q;
    logic              quiet_active;
    logic              last_data;

    assign quiet_active = (quiet_q != '0);
    assign last_data    = (dcnt_q == DCNT_W'(DATA_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HUNT;
            hdr_q   <= '0;
            fcnt_q  <= '0;
            dcnt_q  <= '0;
            shreg_q <= '0;
            hit_q   <= 1'b0;
            run_q   <= '0;
            quiet_q <= QW'(QUIET_CYCLES);
        end else if (quiet_active) begin
            quiet_q <= quiet_q - 1'b1;
            state_q <= ST_HUNT;
            run_q   <= '0;
        end else begin
            case (state_q)
                ST_HUNT: begin
                    if (mdio_i) begin
                        if (run_q == RUN_LAST) begin
                            run_q   <= '0;
                            state_q <= ST_IDLE;
                        end else begin
                            run_q <= run_q + 1'b1;
                        end
                    end else begin
                        run_q <= '0;
                    end
                end
                ST_IDLE: begin
                    if (!mdio_i) state_q <= ST_START;
                end
                ST_START: begin
                    state_q <= mdio_i ? ST_OP1 : ST_HUNT;
                end
                ST_OP1: begin
                    hdr_q.op[1] <= mdio_i;
                    state_q     <= ST_OP2;
                end
                ST_OP2: begin
                    hdr_q.op[0] <= mdio_i;
                    fcnt_q      <= '0;
                    state_q     <= op_is_legal({hdr_q.op[1], mdio_i}) ? ST_PHY : ST_HUNT;
                end
                ST_PHY: begin
                    hdr_q.phy <= {hdr_q.phy[PHY_AW-2:0], mdio_i};
                    if (fcnt_q == FCNT_W'(PHY_AW - 1)) begin
                        fcnt_q  <= '0;
                        state_q <= ST_REG;
                    end else begin
                        fcnt_q <= fcnt_q + 1'b1;
                    end
                end
                ST_REG: begin
                    hdr_q.regad <= {hdr_q.regad[REG_AW-2:0], mdio_i};
                    if (fcnt_q == FCNT_W'(REG_AW - 1)) begin
                        hit_q   <= (hdr_q.phy == my_addr);
                        state_q <= ST_TA1;
                    end else begin
                        fcnt_q <= fcnt_q + 1'b1;
                    end
                end
                ST_TA1: begin
                    if (op_is_read(hdr_q.op)) shreg_q <= rd_data;
                    state_q <= ST_TA2;
                end
                ST_TA2: begin
                    dcnt_q  <= '0;
                    state_q <= ST_DATA;
                end
                ST_DATA: begin
                    shreg_q <= {shreg_q[DATA_W-2:0], mdio_i};
                    if (last_data) begin
                        state_q <= ST_IDLE;
                        hit_q   <= 1'b0;
                    end else begin
                        dcnt_q <= dcnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_HUNT;
            endcase
        end
    end

    assign rd_addr = hdr_q.regad;

    always_comb begin
        wr.en   = (state_q == ST_DATA) && last_data && hit_q && (hdr_q.op == OP_WR);
        wr.addr = hdr_q.regad;
        wr.data = {shreg_q[DATA_W-2:0], mdio_i};
    end

    assign rd_active = hit_q && op_is_read(hdr_q.op) &&
                       ((state_q == ST_TA2) || (state_q == ST_DATA));
    assign ta2_phase = (state_q == ST_TA2);
    assign tx_bit    = shreg_q[DATA_W-1];

    // R5: an illegal opcode drops the frame
    assert_bad_op_aborts_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OP2 && !op_is_legal({hdr_q.op[1], mdio_i})) |=> (state_q == ST_HUNT));

    // R7: nothing is decoded or written during the quiet period
    assert_quiet_no_write_R7: assert property (@(posedge clk) disable iff (rst)
        quiet_active |-> (state_q == ST_HUNT && !wr.en));

endmodule

// File: rtl/mdio_tx_drive.sv
module mdio_tx_drive (
    input  logic clk,
    input  logic rst,
    input  logic rd_active,
    input  logic ta2_phase,
    input  logic tx_bit,
    output logic mdio_oe,
    output logic mdio_o
);

    always_ff @(negedge clk) begin
        if (rst) begin
            mdio_oe <= 1'b0;
            mdio_o  <= 1'b1;
        end else begin
            mdio_oe <= rd_active;
            mdio_o  <= rd_active ? (ta2_phase ? 1'b0 : tx_bit) : 1'b1;
        end
    end

    // R8: the line is only enabled while a matching read is in its drive window
    assert_oe_only_in_read_R8: assert property (@(posedge clk) disable iff (rst)
        mdio_oe |-> rd_active);

    // R3: second turnaround bit of a matching read is a driven zero
    assert_ta2_drives_low_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_active && ta2_phase) |-> (mdio_oe && !mdio_o));

endmodule

// File: rtl/mdio_slave.sv
module mdio_slave
    import mdio_pkg::*;
#(
    parameter int IDLE_RUN     = 8,
    parameter int QUIET_CYCLES = 1
) (
    input  logic       mdc,
    input  logic       rst,
    input  logic       mdio_i,
    input  logic [4:0] strap_addr,
    output logic       mdio_o,
    output logic       mdio_oe
);

    logic [PHY_AW-1:0] my_addr_q;
    logic [REG_AW-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    wr_req_t           wr;
    logic              rd_active;
    logic              ta2_phase;
    logic              tx_bit;

    always_ff @(posedge mdc) begin
        if (rst) my_addr_q <= strap_addr;
    end

    mdio_frame_rx #(
        .IDLE_RUN     (IDLE_RUN),
        .QUIET_CYCLES (QUIET_CYCLES)
    ) u_rx (
        .clk       (mdc),
        .rst       (rst),
        .mdio_i    (mdio_i),
        .my_addr   (my_addr_q),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr        (wr),
        .rd_active (rd_active),
        .ta2_phase (ta2_phase),
        .tx_bit    (tx_bit)
    );

    mdio_regbank u_bank (
        .clk     (mdc),
        .rst     (rst),
        .wr      (wr),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    mdio_tx_drive u_drv (
        .clk       (mdc),
        .rst       (rst),
        .rd_active (rd_active),
        .ta2_phase (ta2_phase),
        .tx_bit    (tx_bit),
        .mdio_oe   (mdio_oe),
        .mdio_o    (mdio_o)
    );

    // R6: the latched address never moves outside reset
    assert_addr_held_R6: assert property (@(posedge mdc) disable iff (rst)
        $stable(my_addr_q));

endmodule

// File: tb/tb_mdio_slave.sv
module tb_mdio_slave;

    localparam int MDC_PERIOD = 40;
    localparam int HALF = MDC_PERIOD / 2;
    localparam logic [4:0] HOME = 5'b10110;

    logic mdc = 1'b0;
    logic rst = 1'b1;
    logic run = 1'b1;
    logic [4:0] strap = HOME;
    logic m_en = 1'b1;
    logic m_val = 1'b1;
    logic line;
    logic mdio_o, mdio_oe;

    int n_tests = 0;
    int n_fail = 0;
    logic [15:0] model [32];

    logic        f_rd_ok, f_any_oe, f_stable;
    logic [15:0] f_rd;

    always_comb line = mdio_oe ? mdio_o : (m_en ? m_val : 1'b1);

    mdio_slave dut (
        .mdc        (mdc),
        .rst        (rst),
        .mdio_i     (line),
        .strap_addr (strap),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe)
    );

    initial forever begin
        #(HALF);
        if (run) mdc = ~mdc;
    end

    initial begin
        #(MDC_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic slot(input logic en, input logic v, output logic s_oe, output logic s_o, output logic s_stable);
        logic p_oe, p_o;
        @(negedge mdc);
        m_en = en;
        m_val = v;
        #(HALF - 4);
        s_oe = mdio_oe;
        s_o = mdio_o;
        @(posedge mdc);
        #2;
        p_oe = mdio_oe;
        p_o = mdio_o;
        s_stable = (p_oe == s_oe) && (p_o == s_o);
    endtask

    task automatic idle(input int n);
        logic a, b, c;
        for (int i = 0; i < n; i++) begin
            slot(1'b0, 1'b1, a, b, c);
            chk(!a, "R8 idle release", {31'd0, a}, 32'd0);
        end
    endtask

    // Sends a frame; bits from index `from` on. Read frames release the line at the turnaround.
    task automatic frame(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra,
                         input logic [15:0] data, input int from);
        logic [31:0] bits;
        logic [31:0] oe_v, o_v;
        logic so, sv, st;
        bit rd;
        bits = {2'b01, op, phy, ra, 2'b10, data};
        rd = (op == 2'b10);
        f_stable = 1'b1;
        oe_v = '0;
        o_v = '0;
        for (int k = from; k < 32; k++) begin
            slot(!(rd && k >= 14), bits[31-k], so, sv, st);
            oe_v[k] = so;
            o_v[k] = sv;
            if (!st) f_stable = 1'b0;
        end
        f_any_oe = (oe_v != 0);
        for (int i = 0; i < 16; i++) f_rd[15-i] = o_v[16+i];
        f_rd_ok = (oe_v[13:0] == 0) && !oe_v[14] && oe_v[15] && !o_v[15] && (oe_v[31:16] == 16'hFFFF);
        m_en = 1'b1;
    endtask

    task automatic do_write(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d, input string req);
        frame(2'b01, phy, ra, d, 0);
        chk(!f_any_oe, {req, " write never drives"}, {31'd0, f_any_oe}, 32'd0);
        chk(f_stable, "R8 outputs steady over rising edge", 32'd0, 32'd1);
    endtask

    task automatic do_read(input logic [4:0] phy, input logic [4:0] ra, input bit hit,
                           input logic [15:0] exp, input string req);
        frame(2'b10, phy, ra, 16'h0, 0);
        if (hit) begin
            chk(f_rd_ok, {req, " R3 turnaround/drive pattern"}, {31'd0, f_rd_ok}, 32'd1);
            chk(f_rd == exp, {req, " read data"}, {16'd0, f_rd}, {16'd0, exp});
        end else begin
            chk(!f_any_oe, {req, " no drive"}, {31'd0, f_any_oe}, 32'd0);
        end
        chk(f_stable, "R8 outputs steady over rising edge", 32'd0, 32'd1);
    endtask

    function automatic logic [4:0] other_addr(input logic [4:0] a, input logic [4:0] r);
        return (r == a) ? ~a : r;
    endfunction

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 32; i++) model[i] = 16'h0000;

        repeat (4) @(posedge mdc);
        #2;
        chk(!mdio_oe, "R8 released during reset", {31'd0, mdio_oe}, 32'd0);

        // R7: write frame whose start bit lands on the first edge after reset release
        @(negedge mdc);
        rst = 1'b0;
        m_en = 1'b1;
        m_val = 1'b0;
        frame(2'b01, HOME, 5'd3, 16'hA5A5, 1);
        idle(12);
        do_read(HOME, 5'd3, 1'b1, 16'h0000, "R7 quiet-edge frame ignored");

        // R11: reset values
        do_read(HOME, 5'd0, 1'b1, 16'h0000, "R11 reset value reg0");
        idle(1);
        do_read(HOME, 5'd31, 1'b1, 16'h0000, "R11 reset value reg31");
        idle(2);

        // R1 R2 R3: write then read back, MSB-first data
        do_write(HOME, 5'd5, 16'h1234, "R2");
        model[5] = 16'h1234;
        idle(2);
        do_read(HOME, 5'd5, 1'b1, 16'h1234, "R1 R2 readback");
        idle(2);
        do_write(HOME, 5'd31, 16'h8001, "R1");
        model[31] = 16'h8001;
        idle(1);
        do_read(HOME, 5'd31, 1'b1, 16'h8001, "R1 MSB first");
        // R9: next frame after a single idle bit
        idle(1);
        do_write(HOME, 5'd0, 16'hFFFF, "R9");
        model[0] = 16'hFFFF;
        idle(1);
        do_read(HOME, 5'd0, 1'b1, 16'hFFFF, "R9 back-to-back");
        idle(2);

        // R4: mismatched address
        do_write(5'b10111, 5'd5, 16'hDEAD, "R4");
        idle(1);
        do_read(5'b00110, 5'd5, 1'b0, 16'h0, "R4 foreign read");
        idle(1);
        do_read(HOME, 5'd5, 1'b1, model[5], "R4 register untouched");
        idle(2);

        // R5: illegal opcodes
        frame(2'b00, HOME, 5'd5, 16'h5A5A, 0);
        chk(!f_any_oe, "R5 op 00 no drive", {31'd0, f_any_oe}, 32'd0);
        idle(12);
        frame(2'b11, HOME, 5'd5, 16'h5A5A, 0);
        chk(!f_any_oe, "R5 op 11 no drive", {31'd0, f_any_oe}, 32'd0);
        idle(12);
        do_read(HOME, 5'd5, 1'b1, model[5], "R5 register untouched");
        idle(2);

        // R6: strap change after reset
        strap = 5'b01001;
        do_write(5'b01001, 5'd7, 16'hBEEF, "R6");
        idle(1);
        do_read(5'b01001, 5'd7, 1'b0, 16'h0, "R6 new strap ignored");
        idle(1);
        do_read(HOME, 5'd7, 1'b1, 16'h0000, "R6 old address answers");
        idle(2);

        // R10: stop the clock while idle
        @(negedge mdc);
        run = 1'b0;
        #(MDC_PERIOD * 25);
        run = 1'b1;
        idle(1);
        do_write(HOME, 5'd9, 16'h0F0F, "R10");
        model[9] = 16'h0F0F;
        idle(1);
        do_read(HOME, 5'd9, 1'b1, 16'h0F0F, "R10 after clock stop");
        idle(2);

        // random mix
        for (int n = 0; n < 60; n++) begin
            logic [4:0] ph, ra;
            logic [15:0] d;
            bit hit;
            hit = ($urandom % 2) == 0;
            ph = hit ? HOME : other_addr(HOME, 5'($urandom));
            ra = 5'($urandom);
            d = 16'($urandom);
            if (($urandom % 2) == 0) begin
                do_write(ph, ra, d, "R2 R4 random");
                if (hit) model[ra] = d;
            end else begin
                do_read(ph, ra, hit, model[ra], "R3 R4 random");
            end
            idle(1 + int'($urandom % 3));
        end
        for (int r = 0; r < 32; r++) begin
            do_read(HOME, 5'(r), 1'b1, model[r], "R2 final sweep");
            idle(1);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule